// File: doc/BRIEF.md
# TLP Trace Capture Selector

This block sits beside a PCIe core's header path and decides, for each observed TLP header, whether the trace engine should store it. Each header event carries the requester ID, the index of the core port it passed through, whether it travels outbound or inbound, its class (posted, non-posted or completion) and, for completions, a flag separating the two inbound completion kinds: A and B. Four configuration words steer the decision:

- a source selector, which is either a port mask or an exact requester ID;
- a class mask;
- a direction code;
- a record-format code, which changes how the direction code is read.

The decision is registered. A `capture` pulse appears one clock after the accepted header event. An illegal configuration raises `cfg_err` and blocks every capture for as long as it stays applied. Header storage, timestamps and memory writes belong to other blocks.

Top module: `tlp_trace_sel`

## Requirements
- R1: `capture` is high in the cycle after a cycle in which `hdr_valid` was high and all source, class and direction criteria held with a legal configuration. `capture` is low after any cycle with `hdr_valid` low.
- R2: With `cfg_filter[19]` = 0 (requester mode), a header matches the source criterion only when `hdr_rid` equals `cfg_filter[15:0]`.
- R3: With `cfg_filter[19]` = 1 (port mode), a header matches the source criterion when `cfg_filter[hdr_port]` is 1. Several ports may be enabled at once.
- R4: Class codes on `hdr_class` are 0 = posted, 1 = non-posted, 2 = completion and 3 = unused. The class criterion holds when `cfg_type` bit 0, 1 or 2 is set for class 0, 1 or 2 respectively. Class 3 and `cfg_type[7:3]` never match.
- R5: With `cfg_fmt` = 0 (short record), the direction codes behave as follows:
  - 0 passes all inbound headers.
  - 1 passes all outbound headers.
  - 2 passes outbound headers, plus inbound headers except completions of kind A (`hdr_cpl_b` = 0).
  - 3 passes outbound headers, plus inbound completions of kind A only.
- R6: With `cfg_fmt` = 1 (long record), the direction codes behave as follows:
  - 1 passes outbound headers only.
  - 2 passes inbound headers except completions of kind A.
  - 3 passes inbound completions of kind A only.
- R7: If the direction code passes outbound headers and more than one bit of `cfg_type` is set, the configuration is illegal. Several type bits with an inbound-only direction are legal.
- R8: A nonzero value in the reserved bits `cfg_filter[18:16]` makes the configuration illegal.
- R9: The configuration is illegal if the direction code is 0 with `cfg_fmt` = 1, if the direction code is above 3, or if `cfg_fmt` is above 1.
- R10: `cfg_err` equals the legality verdict on the configuration present one cycle earlier. A header seen in a cycle with an illegal configuration is never captured.
- R11: While `rst_n` is low, `capture` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | A header event is present this cycle |
| hdr_rid | input | 16 | Requester ID of the header |
| hdr_port | input | 4 | Core port index the header passed |
| hdr_out | input | 1 | 1 = outbound, 0 = inbound |
| hdr_class | input | 2 | 0 posted, 1 non-posted, 2 completion |
| hdr_cpl_b | input | 1 | Completion kind: 1 = B, 0 = A |
| cfg_filter | input | 20 | Bit 19 mode, 18:16 reserved, 15:0 mask or ID |
| cfg_type | input | 8 | Class mask |
| cfg_dir | input | 4 | Direction code |
| cfg_fmt | input | 4 | Record format code |
| capture | output | 1 | Registered capture decision |
| cfg_err | output | 1 | Registered configuration-illegal flag |

## Verification
A header event and a configuration change can land in the same cycle. The case that matters is a legal setup that turns illegal exactly when a matching header arrives. The bench provokes this by driving the reserved filter bits, an outbound direction with two class bits, and the header together on one clock. The edge that follows must show `cfg_err` high and `capture` low. The legal configuration is then restored in the same cycle as another matching header, and the next edge must show `capture` high and `cfg_err` low.

// File: rtl/tlp_trace_sel.sv
module tlp_trace_sel #(
  parameter int RID_W    = 16,
  parameter int PORT_CNT = 16,
  parameter int TYPE_W   = 8,
  parameter int DIR_W    = 4,
  parameter int FMT_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hdr_valid,
  input  logic [RID_W-1:0]            hdr_rid,
  input  logic [$clog2(PORT_CNT)-1:0] hdr_port,
  input  logic                        hdr_out,
  input  logic [1:0]                  hdr_class,
  input  logic                        hdr_cpl_b,
  input  logic [RID_W+3:0]            cfg_filter,
  input  logic [TYPE_W-1:0]           cfg_type,
  input  logic [DIR_W-1:0]            cfg_dir,
  input  logic [FMT_W-1:0]            cfg_fmt,
  output logic                        capture,
  output logic                        cfg_err
);
  localparam int FILT_W   = RID_W + 4;
  localparam int MODE_BIT = FILT_W - 1;
  localparam logic [1:0] CLS_P   = 2'd0;
  localparam logic [1:0] CLS_NP  = 2'd1;
  localparam logic [1:0] CLS_CPL = 2'd2;

  logic long_fmt, fmt_bad, dir_bad, res_bad, multi_type, takes_out, err_c;
  logic cls_hit, src_hit, dir_hit, in_hit, cpl_a;
  logic in_all, in_no_a, in_only_a;
  logic [PORT_CNT-1:0] port_mask;

  assign long_fmt   = (cfg_fmt == FMT_W'(1));
  assign fmt_bad    = (cfg_fmt > FMT_W'(1));
  assign dir_bad    = (cfg_dir > DIR_W'(3)) || (long_fmt && cfg_dir == '0);
  assign res_bad    = |cfg_filter[MODE_BIT-1:RID_W];
  assign multi_type = ($countones(cfg_type) > 1);

  always_comb begin
    takes_out = 1'b0;
    in_all    = 1'b0;
    in_no_a   = 1'b0;
    in_only_a = 1'b0;
    case (cfg_dir)
      DIR_W'(0): in_all = !long_fmt;
      DIR_W'(1): takes_out = 1'b1;
      DIR_W'(2): begin
        takes_out = !long_fmt;
        in_no_a   = 1'b1;
      end
      DIR_W'(3): begin
        takes_out = !long_fmt;
        in_only_a = 1'b1;
      end
      default: ;
    endcase
  end

  assign err_c = res_bad | fmt_bad | dir_bad | (takes_out & multi_type);

  always_comb begin
    case (hdr_class)
      CLS_P:   cls_hit = cfg_type[0];
      CLS_NP:  cls_hit = cfg_type[1];
      CLS_CPL: cls_hit = cfg_type[2];
      default: cls_hit = 1'b0;
    endcase
  end

  assign port_mask = cfg_filter[PORT_CNT-1:0];
  assign src_hit   = cfg_filter[MODE_BIT] ? port_mask[hdr_port]
                                          : (hdr_rid == cfg_filter[RID_W-1:0]);

  assign cpl_a   = (hdr_class == CLS_CPL) && !hdr_cpl_b;
  assign in_hit  = in_all | (in_no_a & !cpl_a) | (in_only_a & cpl_a);
  assign dir_hit = hdr_out ? takes_out : in_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capture <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      capture <= hdr_valid & src_hit & cls_hit & dir_hit & !err_c;
      cfg_err <= err_c;
    end
  end
endmodule

// File: rtl/tlp_trace_sel_chk.sv
module tlp_trace_sel_chk #(
  parameter int RID_W    = 16,
  parameter int PORT_CNT = 16,
  parameter int TYPE_W   = 8,
  parameter int DIR_W    = 4,
  parameter int FMT_W    = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        hdr_valid,
  input logic [RID_W-1:0]            hdr_rid,
  input logic [$clog2(PORT_CNT)-1:0] hdr_port,
  input logic [1:0]                  hdr_class,
  input logic [RID_W+3:0]            cfg_filter,
  input logic [TYPE_W-1:0]           cfg_type,
  input logic [DIR_W-1:0]            cfg_dir,
  input logic [FMT_W-1:0]            cfg_fmt,
  input logic                        capture,
  input logic                        cfg_err
);
  localparam int MB = RID_W + 3;
  logic [PORT_CNT-1:0] pm;
  assign pm = cfg_filter[PORT_CNT-1:0];

  a_r1_no_valid_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> !capture);

  a_r2_rid_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !cfg_filter[MB] && hdr_rid != cfg_filter[RID_W-1:0]) |=> !capture);

  a_r3_port_off: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && cfg_filter[MB] && !pm[hdr_port]) |=> !capture);

  a_r4_unused_class: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_class == 2'd3) |=> !capture);

  a_r8_reserved_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_filter[MB-1:RID_W] != '0) |=> (cfg_err && !capture));

  a_r9_long_dir_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fmt == FMT_W'(1) && cfg_dir == '0) |=> cfg_err);

  a_r10_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !capture);
endmodule

bind tlp_trace_sel tlp_trace_sel_chk #(
  .RID_W(RID_W), .PORT_CNT(PORT_CNT), .TYPE_W(TYPE_W), .DIR_W(DIR_W), .FMT_W(FMT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_rid(hdr_rid),
  .hdr_port(hdr_port), .hdr_class(hdr_class), .cfg_filter(cfg_filter),
  .cfg_type(cfg_type), .cfg_dir(cfg_dir), .cfg_fmt(cfg_fmt),
  .capture(capture), .cfg_err(cfg_err)
);

// File: tb/tlp_trace_sel_test.sv
module tlp_trace_sel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0;
  logic [15:0] hdr_rid = '0;
  logic [3:0]  hdr_port = '0;
  logic        hdr_out = 1'b0;
  logic [1:0]  hdr_class = '0;
  logic        hdr_cpl_b = 1'b0;
  logic [19:0] cfg_filter = '0;
  logic [7:0]  cfg_type = 8'h01;
  logic [3:0]  cfg_dir = '0;
  logic [3:0]  cfg_fmt = '0;
  logic        capture, cfg_err;
  int total = 0;
  int failed = 0;

  always #10 clk = ~clk;

  tlp_trace_sel uut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_rid(hdr_rid),
    .hdr_port(hdr_port), .hdr_out(hdr_out), .hdr_class(hdr_class),
    .hdr_cpl_b(hdr_cpl_b), .cfg_filter(cfg_filter), .cfg_type(cfg_type),
    .cfg_dir(cfg_dir), .cfg_fmt(cfg_fmt), .capture(capture), .cfg_err(cfg_err)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    total++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic set_cfg(input logic [19:0] f, input logic [7:0] t,
                         input logic [3:0] d, input logic [3:0] m,
                         input logic exp_err, input string tag);
    @(negedge clk);
    cfg_filter = f; cfg_type = t; cfg_dir = d; cfg_fmt = m;
    @(posedge clk); #1;
    check(cfg_err, exp_err, tag);
  endtask

  task automatic send(input logic [15:0] rid, input logic [3:0] port,
                      input logic out, input logic [1:0] cls, input logic cb,
                      input logic vld, input logic exp, input string tag);
    @(negedge clk);
    hdr_rid = rid; hdr_port = port; hdr_out = out;
    hdr_class = cls; hdr_cpl_b = cb; hdr_valid = vld;
    @(posedge clk); #1;
    hdr_valid = 1'b0;
    check(capture, exp, tag);
  endtask

  task automatic t_reset();
    check(capture, 1'b0, "R11 capture in reset");
    check(cfg_err, 1'b0, "R11 cfg_err in reset");
  endtask

  task automatic t_requester();
    set_cfg(20'h00101, 8'h01, 4'd0, 4'd0, 1'b0, "R2 legal requester cfg");
    send(16'h0101, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, "R1 R2 matching rid");
    send(16'h0102, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R2 other rid");
    send(16'h0101, 4'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R1 no valid");
  endtask

  task automatic t_port();
    set_cfg(20'h80024, 8'h07, 4'd0, 4'd0, 1'b0, "R3 port cfg");
    send(16'hBEEF, 4'd2, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, "R3 port 2 on");
    send(16'h1234, 4'd5, 1'b0, 2'd2, 1'b1, 1'b1, 1'b1, "R3 port 5 on");
    send(16'h0024, 4'd3, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R3 port 3 off");
  endtask

  task automatic t_type();
    set_cfg(20'h00042, 8'h02, 4'd0, 4'd0, 1'b0, "R4 np only cfg");
    send(16'h0042, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R4 posted blocked");
    send(16'h0042, 4'd0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, "R4 non-posted pass");
    send(16'h0042, 4'd0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, "R4 completion blocked");
    set_cfg(20'h00042, 8'h0F, 4'd0, 4'd0, 1'b0, "R4 all bits cfg");
    send(16'h0042, 4'd0, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, "R4 class 3 never");
    set_cfg(20'h00042, 8'h08, 4'd0, 4'd0, 1'b0, "R4 upper bit cfg");
    send(16'h0042, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R4 upper type bit");
  endtask

  task automatic t_dir_short();
    set_cfg(20'h00001, 8'h01, 4'd1, 4'd0, 1'b0, "R5 dir1 cfg");
    send(16'h0001, 4'd0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, "R5 dir1 outbound");
    send(16'h0001, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R5 dir1 inbound");
    set_cfg(20'h00001, 8'h04, 4'd2, 4'd0, 1'b0, "R5 dir2 cfg");
    send(16'h0001, 4'd0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b1, "R5 dir2 in cpl B");
    send(16'h0001, 4'd0, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0, "R5 dir2 in cpl A");
    send(16'h0001, 4'd0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1, "R5 dir2 out cpl");
    set_cfg(20'h00001, 8'h04, 4'd3, 4'd0, 1'b0, "R5 dir3 cfg");
    send(16'h0001, 4'd0, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, "R5 dir3 in cpl A");
    send(16'h0001, 4'd0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, "R5 dir3 in cpl B");
    set_cfg(20'h00001, 8'h01, 4'd3, 4'd0, 1'b0, "R5 dir3 posted cfg");
    send(16'h0001, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R5 dir3 in posted");
  endtask

  task automatic t_dir_long();
    set_cfg(20'h00001, 8'h04, 4'd1, 4'd1, 1'b0, "R6 dir1 cfg");
    send(16'h0001, 4'd0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1, "R6 dir1 outbound");
    send(16'h0001, 4'd0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, "R6 dir1 inbound");
    set_cfg(20'h00001, 8'h04, 4'd2, 4'd1, 1'b0, "R6 dir2 cfg");
    send(16'h0001, 4'd0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b1, "R6 dir2 in cpl B");
    send(16'h0001, 4'd0, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, "R6 dir2 outbound");
    set_cfg(20'h00001, 8'h04, 4'd3, 4'd1, 1'b0, "R6 dir3 cfg");
    send(16'h0001, 4'd0, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, "R6 dir3 in cpl A");
    send(16'h0001, 4'd0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, "R6 dir3 in cpl B");
  endtask

  task automatic t_errors();
    set_cfg(20'h00001, 8'h07, 4'd0, 4'd0, 1'b0, "R7 inbound multi legal");
    send(16'h0001, 4'd0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, "R7 inbound multi captures");
    set_cfg(20'h00001, 8'h03, 4'd1, 4'd0, 1'b1, "R7 outbound multi illegal");
    send(16'h0001, 4'd0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, "R10 err blocks capture");
    set_cfg(20'h10001, 8'h01, 4'd0, 4'd0, 1'b1, "R8 reserved filter bit");
    set_cfg(20'h00001, 8'h01, 4'd0, 4'd1, 1'b1, "R9 long fmt dir0");
    set_cfg(20'h00001, 8'h01, 4'd5, 4'd0, 1'b1, "R9 dir above 3");
    set_cfg(20'h00001, 8'h01, 4'd0, 4'd2, 1'b1, "R9 fmt above 1");
    set_cfg(20'h00001, 8'h01, 4'd0, 4'd0, 1'b0, "R10 err clears");
  endtask

  task automatic t_collide();
    @(negedge clk);
    cfg_filter = 20'h10001; cfg_type = 8'h03; cfg_dir = 4'd1; cfg_fmt = 4'd0;
    hdr_rid = 16'h0001; hdr_out = 1'b1; hdr_class = 2'd0; hdr_valid = 1'b1;
    @(posedge clk); #1;
    check(cfg_err, 1'b1, "R10 collide err");
    check(capture, 1'b0, "R10 collide capture");
    @(negedge clk);
    cfg_filter = 20'h00001; cfg_type = 8'h01;
    @(posedge clk); #1;
    hdr_valid = 1'b0;
    check(cfg_err, 1'b0, "R10 restore err");
    check(capture, 1'b1, "R1 restore capture");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_requester();
    t_port();
    t_type();
    t_dir_short();
    t_dir_long();
    t_errors();
    t_collide();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #(20 * 200000);
    failed++;
    total++;
    $display("FAIL watchdog R1: got timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule